// File: doc/BRIEF.md
# Width-Adaptive Prefix Adder

A purely combinational adder for two N-bit unsigned operands with no carry input. The result keeps the operand width, so the final carry out of the top bit is discarded and results wrap modulo 2^N. A mode input turns the block into a subtractor: the second operand is bit-inverted and an extra one is added at bit 0.

The carry network is picked from N when the block is elaborated. Widths below 8 use a serial carry chain. Widths from 8 to 31 use a Kogge-Stone tree. Widths of 32 and above use a Brent-Kung tree, which has an upward and a downward sweep. Every variant is built from the same parts. Each bit forms a propagate term (XOR of its operand bits) and a generate term (AND of its operand bits). Group cells merge a higher span i with a lower span j: the group generate becomes G_i | (P_i & G_j) and the group propagate becomes P_i & P_j. The sum bits are each bit's propagate XOR the carry coming in from below. The design uses no behavioural `+` operator.

Top module: `prefix_adder`

## Requirements
- R1: For N below 8 (widths 1 and 7 are exercised), with sub_i = 0, sum_o equals (a_i + b_i) mod 2^N. A serial carry chain produces the result.
- R2: For N from 8 to 31 (widths 8, 16 and 31 are exercised), sum_o equals the modular sum or difference of the operands. A Kogge-Stone tree produces the result.
- R3: For N of 32 or more (widths 32 and 40 are exercised), sum_o equals the modular sum or difference of the operands. A two-sweep Brent-Kung tree produces the result.
- R4: The carry out of bit N-1 is discarded. All-ones plus one gives zero.
- R5: With sub_i = 1, sum_o equals (a_i - b_i) mod 2^N, computed as a_i + ~b_i + 1. The +1 is folded into the bit-0 generate term.
- R6: With sub_i = 1, equal operands give zero, and 0 minus 1 gives all ones.
- R7: In both modes, sum_o[0] equals a_i[0] XOR b_i[0].
- R8: When every bit from 0 up to bit i propagates, the carry out of bit i equals the injected bit (sub_i). As a result, a_i plus ~a_i in add mode gives all ones.
- R9: A zero second operand returns a_i unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand (minuend in subtract mode) |
| b_i | input | N | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| sum_o | output | N | Result modulo 2^N |

## Verification
The assertions in the top module are evaluated whenever any input changes. They check the bit-0 parity rule, the rule that a run of propagating bits passes the injected bit through unchanged, the zero result for equal operands in subtract mode, and the identity for a zero second operand. Full arithmetic correctness for each topology, the wrap at 2^N and the borrow into all ones can only be shown by the bench's scenarios. The bench compares seven widths, chosen to sit on both sides of each threshold, against a behavioural sum.

// File: rtl/padd_pkg.sv
// Package: shared topology selection for the prefix adder.
// Assumes N >= 1; the thresholds decide which carry network is built.
package padd_pkg;

    typedef enum logic [1:0] {
        TOPO_CHAIN = 2'd0,
        TOPO_KS    = 2'd1,
        TOPO_BK    = 2'd2
    } topo_e;

    localparam int KS_MIN_W = 8;
    localparam int BK_MIN_W = 32;

    // Map an operand width to the carry network that serves it.
    function automatic topo_e pick_topo(input int width);
        if (width < KS_MIN_W)      return TOPO_CHAIN;
        else if (width < BK_MIN_W) return TOPO_KS;
        else                       return TOPO_BK;
    endfunction

endpackage

// File: rtl/padd_pg_stage.sv
// Module: per-bit propagate/generate formation.
// Inverts the second operand in subtract mode and folds the injected
// one into the bit-0 generate term, so the networks see no carry-in.
module padd_pg_stage #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    output logic [N-1:0] p_o,
    output logic [N-1:0] g_o
);
    logic [N-1:0] b_eff;
    logic [N-1:0] g_raw;

    // Operand conditioning and raw bit terms.
    always_comb begin
        b_eff = b_i ^ {N{sub_i}};
        p_o   = a_i ^ b_eff;
        g_raw = a_i & b_eff;
    end

    // Fold the carry-in into bit 0; other bits pass through.
    always_comb begin
        g_o    = g_raw;
        g_o[0] = g_raw[0] | (p_o[0] & sub_i);
    end
endmodule

// File: rtl/padd_chain_net.sv
// Module: serial carry chain for narrow widths.
// Output bit i is the carry out of bit i (group generate of 0..i)
// and the AND of all propagates 0..i.
module padd_chain_net #(
    parameter int N = 4
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    output logic [N-1:0] gg_o,
    output logic [N-1:0] gp_o
);
    // Bit 0 starts the chain with no carry input.
    assign gg_o[0] = g_i[0];
    assign gp_o[0] = p_i[0];

    for (genvar i = 1; i < N; i++) begin : g_link
        // Each link merges its own bit with everything below it.
        assign gg_o[i] = g_i[i] | (p_i[i] & gg_o[i-1]);
        assign gp_o[i] = p_i[i] & gp_o[i-1];
    end
endmodule

// File: rtl/padd_ks_net.sv
// Module: Kogge-Stone prefix network.
// At stride s = 1,2,4,... (s < N) every position i >= s merges with i-s.
// Produces full prefixes: bit i covers positions 0..i.
module padd_ks_net #(
    parameter int N = 16
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    output logic [N-1:0] gg_o,
    output logic [N-1:0] gp_o
);
    localparam int LVLS = $clog2(N);

    logic [N-1:0] gv [0:LVLS];
    logic [N-1:0] pv [0:LVLS];

    assign gv[0] = g_i;
    assign pv[0] = p_i;

    for (genvar k = 0; k < LVLS; k++) begin : g_lvl
        localparam int S = 1 << k;
        for (genvar i = 0; i < N; i++) begin : g_pos
            if (i >= S) begin : g_merge
                // Group cell: merge span ending at i with span ending at i-S.
                assign gv[k+1][i] = gv[k][i] | (pv[k][i] & gv[k][i-S]);
                assign pv[k+1][i] = pv[k][i] & pv[k][i-S];
            end else begin : g_pass
                // Already a full prefix; forward unchanged.
                assign gv[k+1][i] = gv[k][i];
                assign pv[k+1][i] = pv[k][i];
            end
        end
    end

    assign gg_o = gv[LVLS];
    assign gp_o = pv[LVLS];
endmodule

// File: rtl/padd_bk_net.sv
// Module: Brent-Kung prefix network.
// Upward sweep at stride s merges i = 2s-1, 4s-1, ... with i-s; the
// downward sweep, halving s, merges i = 3s-1, 5s-1, ... with i-s.
module padd_bk_net #(
    parameter int N = 32
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    output logic [N-1:0] gg_o,
    output logic [N-1:0] gp_o
);
    localparam int LVLS = $clog2(N);
    localparam int ALL  = 2 * LVLS;

    logic [N-1:0] gv [0:ALL];
    logic [N-1:0] pv [0:ALL];

    assign gv[0] = g_i;
    assign pv[0] = p_i;

    for (genvar k = 0; k < ALL; k++) begin : g_lvl
        localparam bit UP = (k < LVLS);
        localparam int S  = UP ? (1 << k) : (1 << (ALL - 1 - k));
        for (genvar i = 0; i < N; i++) begin : g_pos
            localparam bit HIT = UP ? (((i + 1) % (2 * S)) == 0)
                                    : ((i >= 3 * S - 1) && (((i + 1 - S) % (2 * S)) == 0));
            if (HIT) begin : g_merge
                // Group cell on the scheduled position.
                assign gv[k+1][i] = gv[k][i] | (pv[k][i] & gv[k][i-S]);
                assign pv[k+1][i] = pv[k][i] & pv[k][i-S];
            end else begin : g_pass
                // Position idle at this level.
                assign gv[k+1][i] = gv[k][i];
                assign pv[k+1][i] = pv[k][i];
            end
        end
    end

    assign gg_o = gv[ALL];
    assign gp_o = pv[ALL];
endmodule

// File: rtl/prefix_adder.sv
// Module: width-adaptive N-bit adder/subtractor, combinational.
// Picks a chain, Kogge-Stone or Brent-Kung carry network from N.
// Assumes N >= 1. The carry out of the top bit is discarded.
module prefix_adder #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    output logic [N-1:0] sum_o
);
    localparam padd_pkg::topo_e TOPO = padd_pkg::pick_topo(N);

    logic [N-1:0] p_bit;
    logic [N-1:0] g_bit;
    logic [N-1:0] grp_g;
    logic [N-1:0] grp_p;

    padd_pg_stage #(.N(N)) u_pg (
        .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .p_o(p_bit), .g_o(g_bit)
    );

    if (TOPO == padd_pkg::TOPO_CHAIN) begin : g_chain
        padd_chain_net #(.N(N)) u_net (
            .p_i(p_bit), .g_i(g_bit), .gg_o(grp_g), .gp_o(grp_p)
        );
    end else if (TOPO == padd_pkg::TOPO_KS) begin : g_ks
        padd_ks_net #(.N(N)) u_net (
            .p_i(p_bit), .g_i(g_bit), .gg_o(grp_g), .gp_o(grp_p)
        );
    end else begin : g_bk
        padd_bk_net #(.N(N)) u_net (
            .p_i(p_bit), .g_i(g_bit), .gg_o(grp_g), .gp_o(grp_p)
        );
    end

    // Sum: bit propagate XOR carry from below (injected bit at bit 0).
    always_comb begin
        sum_o[0] = p_bit[0] ^ sub_i;
        for (int i = 1; i < N; i++) sum_o[i] = p_bit[i] ^ grp_g[i-1];
    end

    // Guards on the finished result and the network prefixes.
    always_comb begin
        // R7
        bit0_parity_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
            else $error("bit 0 not a0^b0");
        // R6
        self_sub_zero_chk: assert (!(sub_i && (a_i == b_i)) || (sum_o == '0))
            else $error("a-a nonzero");
        // R9
        zero_operand_chk: assert (!(b_i == '0) || (sum_o == a_i))
            else $error("zero operand changed a");
        for (int i = 0; i < N; i++) begin
            // R8
            prop_run_chk: assert (!grp_p[i] || (grp_g[i] == sub_i))
                else $error("propagate run carry mismatch at %0d", i);
        end
    end
endmodule

// File: tb/prefix_adder_bench.sv
// Bench: seven widths around the topology thresholds against a
// behavioural modular sum, compared every clock.
module prefix_adder_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [63:0] a_d = '0;
    logic [63:0] b_d = '0;
    logic        s_d = 1'b0;

    logic [0:0]  y1;
    logic [6:0]  y7;
    logic [7:0]  y8;
    logic [15:0] y16;
    logic [30:0] y31;
    logic [31:0] y32;
    logic [39:0] y40;

    prefix_adder #(.N(1))  u_prefix_adder_w1  (.a_i(a_d[0:0]),  .b_i(b_d[0:0]),  .sub_i(s_d), .sum_o(y1));
    prefix_adder #(.N(7))  u_prefix_adder_w7  (.a_i(a_d[6:0]),  .b_i(b_d[6:0]),  .sub_i(s_d), .sum_o(y7));
    prefix_adder #(.N(8))  u_prefix_adder_w8  (.a_i(a_d[7:0]),  .b_i(b_d[7:0]),  .sub_i(s_d), .sum_o(y8));
    prefix_adder #(.N(16)) u_prefix_adder     (.a_i(a_d[15:0]), .b_i(b_d[15:0]), .sub_i(s_d), .sum_o(y16));
    prefix_adder #(.N(31)) u_prefix_adder_w31 (.a_i(a_d[30:0]), .b_i(b_d[30:0]), .sub_i(s_d), .sum_o(y31));
    prefix_adder #(.N(32)) u_prefix_adder_w32 (.a_i(a_d[31:0]), .b_i(b_d[31:0]), .sub_i(s_d), .sum_o(y32));
    prefix_adder #(.N(40)) u_prefix_adder_w40 (.a_i(a_d[39:0]), .b_i(b_d[39:0]), .sub_i(s_d), .sum_o(y40));

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    function automatic logic [63:0] wmask(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic s, input int n);
        logic [63:0] r;
        r = s ? (a - b) : (a + b);
        return r & wmask(n);
    endfunction

    function automatic string wtag(input int n);
        if (n < 8)       return "R1";
        else if (n < 32) return "R2";
        else             return "R3";
    endfunction

    task automatic chk(input int n, input logic [63:0] got, input string tag);
        logic [63:0] exp;
        exp = model(a_d, b_d, s_d, n);
        n_run++;
        if ((got & wmask(n)) !== exp) begin
            n_fail++;
            $display("FAIL %s/%s N=%0d a=%h b=%h sub=%0b got=%h exp=%h",
                     tag, wtag(n), n, a_d & wmask(n), b_d & wmask(n), s_d,
                     got & wmask(n), exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(1,  {63'd0, y1},  tag);
        chk(7,  {57'd0, y7},  tag);
        chk(8,  {56'd0, y8},  tag);
        chk(16, {48'd0, y16}, tag);
        chk(31, {33'd0, y31}, tag);
        chk(32, {32'd0, y32}, tag);
        chk(40, {24'd0, y40}, tag);
    endtask

    // Drive on the rising edge, compare on the falling edge.
    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic s, input string tag);
        @(posedge clk);
        a_d = a;
        b_d = b;
        s_d = s;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        // Idle: zero inputs give zero (R9 identity at every width).
        @(negedge clk);
        check_all("R9");
        // R4: all ones plus one wraps to zero.
        apply('1, 64'd1, 1'b0, "R4");
        // R8: every bit propagates, no carry appears.
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R8");
        apply(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b0, "R8");
        // R6: equal operands and zero minus one.
        apply(64'h0F0F_1234_5678_9ABC, 64'h0F0F_1234_5678_9ABC, 1'b1, "R6");
        apply(64'd0, 64'd1, 1'b1, "R6");
        // R9: zero second operand in subtract mode.
        apply(64'hDEAD_BEEF_CAFE_F00D, 64'd0, 1'b1, "R9");
        // R5: full-borrow ripple and random subtractions.
        apply(64'h8000_0000_0000_0000, 64'd1, 1'b1, "R5");
        for (int k = 0; k < 150; k++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'b1, "R5");
        // R7: odd/even low bits in both modes.
        for (int k = 0; k < 40; k++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, k[0], "R7");
        // R1/R2/R3: random additions, width class named in each message.
        for (int k = 0; k < 300; k++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "ADD");
        done = 1'b1;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule